// File: doc/BRIEF.md
# Unrolled Soft-Cancellation Polar Decoder

This block decodes one frame of a short polar code per clock. A frame arrives as N channel log-likelihood ratios (LLRs). The block returns N hard message bits. Decoding visits the binary code tree depth-first, in a single soft-cancellation pass. The tree is unrolled so that every visit, down into a child or back up out of it, is its own hardware stage. For N leaves that gives 2·(2N−2) stages.

Going down, a stage forms child LLRs from the parent with min-sum arithmetic. Coming back up, a stage forms soft estimates (beta vectors) that it returns to the parent. Leaves make no hard decision inside the tree: a frozen leaf sends back the largest positive LLR and an information leaf sends back zero. A stage-boundary mask chooses where pipeline registers sit. The choices run from a purely combinational decoder, through any subset of boundaries, to a register after every stage. A valid flag moves with the data, so a new frame can enter on every clock.

The code length, the LLR width and the frozen-position mask are parameters. All arithmetic saturates symmetrically at ±(2^(W−1)−1).

Top module: `pscan_decoder`

## Requirements
- R1: `in_llr` carries LLR i in bits [i*W +: W], in two's complement, and a positive value favours bit 0. Leaf j of the tree drives `out_bits[j]`. The codeword is x = u·G: start from x = u, then for each h in 1, 2, 4, … below N, set x[i] ^= x[i+h] for every i whose bit h is clear. If every LLR is nonzero and its sign agrees with x, the decoder returns u. The default frozen mask is 8'h17, where bit j set means position j is frozen.
- R2: Every frozen position of `out_bits` is 0 for every frame, whatever the input.
- R3: An information bit is 1 exactly when the leaf's LLR plus its returned soft value is negative. A sum of zero gives 0, so an all-zero frame decodes to all zeros.
- R4: The most negative input code is taken as −(2^(W−1)−1). No internal LLR or soft value ever holds the most negative code.
- R5: Down-left stages use min-sum, so no output magnitude exceeds its input magnitude. With W=6, a single position of magnitude 1 and wrong sign, with every other position at magnitude 20, still decodes to the sent message.
- R6: There are exactly 2·(2N−2) stages. Bit k of `REG_MASK` places a register after stage k. The latency in cycles equals the number of set bits among the low 2·(2N−2) bits of the mask.
- R7: `out_valid` is `in_valid` delayed by that latency. With an all-zero mask, `out_valid` and `out_bits` follow the inputs within the same cycle.
- R8: Frames presented on consecutive cycles come out on consecutive cycles, in order, each decoded independently.
- R9: Reset clears every valid flag in flight. No frame accepted before reset ever appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst_n | input | 1 | Asynchronous active-low reset of the valid flags |
| in_valid | input | 1 | Frame on `in_llr` is valid this cycle |
| in_llr | input | N*W | N channel LLRs, position i in bits [i*W +: W] |
| out_valid | output | 1 | `out_bits` holds a decoded frame |
| out_bits | output | N | Hard message estimate, leaf j at bit j |

## Verification
The hardest situation to reach from the ports is a reset that lands while frames occupy registers deep in the pipeline. It only tests anything if the frames were accepted recently enough that none has come out yet. The bench therefore runs a fully registered, a partially registered and a combinational copy side by side, fills them with a burst of frames, and pulls reset one cycle later. It then watches a full pipeline depth of idle cycles for any stale valid. The clamp of the most negative code, zero-sum ties and weak wrong-sign inputs are each reached with crafted frames whose expected messages follow from the encoding rule.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

   // depth of a node in heap numbering (root = 1 sits at depth 0)
   function automatic int node_level(int id);
      int l;
      l = 0;
      while ((id >> (l + 1)) != 0) l++;
      return l;
   endfunction

   // event k of the depth-first walk, encoded as node*2 + leaving
   function automatic int trav_event(int depth, int k);
      int nd;
      int lv;
      nd = 2;
      lv = 0;
      for (int s = 0; s < k; s++) begin
         if (lv == 0) begin
            if (node_level(nd) == depth) lv = 1;
            else nd = 2 * nd;
         end else if ((nd % 2) == 0) begin
            nd = nd + 1;
            lv = 0;
         end else begin
            nd = nd / 2;
            lv = 1;
         end
      end
      return nd * 2 + lv;
   endfunction

   function automatic int popc(logic [63:0] m, int n);
      int c;
      c = 0;
      for (int i = 0; i < 64; i++) if (i < n && m[i]) c++;
      return c;
   endfunction

   function automatic int sat(int v, int mx);
      return (v > mx) ? mx : ((v < -mx) ? -mx : v);
   endfunction

   function automatic int iabs(int v);
      return (v < 0) ? -v : v;
   endfunction

   // min-sum approximation of the box-plus operation
   function automatic int fmin(int a, int b);
      int m;
      m = (iabs(a) < iabs(b)) ? iabs(a) : iabs(b);
      return ((a < 0) != (b < 0)) ? -m : m;
   endfunction

endpackage

// File: rtl/pscan_clamp.sv
module pscan_clamp #(
   parameter int N = 8,
   parameter int W = 6
) (
   input  logic [N*W-1:0]        raw,
   output logic [N-1:0][W-1:0]   llr
);
   localparam logic [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] NEGM = {1'b1, {(W-2){1'b0}}, 1'b1};

   for (genvar i = 0; i < N; i++) begin : g_lane
      assign llr[i] = (raw[i*W +: W] == MINC) ? NEGM : raw[i*W +: W];
   end
endmodule

// File: rtl/pscan_stage.sv
module pscan_stage
   import pscan_pkg::*;
#(
   parameter int          N      = 8,
   parameter int          W      = 6,
   parameter int          LV     = 3,
   parameter int          STEP   = 0,
   parameter logic [N-1:0] FROZEN = '0,
   parameter bit          REG    = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          v_i,
   input  logic [LV:0][N-1:0][W-1:0]     a_i,
   input  logic [LV:0][N-1:0][W-1:0]     bl_i,
   input  logic [LV:0][N-1:0][W-1:0]     br_i,
   input  logic [N-1:0]                  u_i,
   output logic                          v_o,
   output logic [LV:0][N-1:0][W-1:0]     a_o,
   output logic [LV:0][N-1:0][W-1:0]     bl_o,
   output logic [LV:0][N-1:0][W-1:0]     br_o,
   output logic [N-1:0]                  u_o
);
   localparam int EV    = trav_event(LV, STEP);
   localparam int NODE  = EV / 2;
   localparam bit LEAVE = (EV % 2) == 1;
   localparam bit RIGHT = (NODE % 2) == 1;
   localparam int T     = node_level(NODE);
   localparam int J     = NODE - (1 << T);
   localparam int M     = N >> T;
   localparam int H     = M / 2;
   localparam int MX    = (1 << (W - 1)) - 1;
   localparam logic [W-1:0] MINC = {1'b1, {(W-1){1'b0}}};

   function automatic int sv(logic [W-1:0] x);
      return int'($signed(x));
   endfunction

   logic [LV:0][N-1:0][W-1:0] a_n, bl_n, br_n;
   logic [N-1:0]              u_n;

   if (!LEAVE && !RIGHT) begin : g_down_left
      logic fb_bad;
      always_comb begin
         a_n = a_i; bl_n = bl_i; br_n = br_i; u_n = u_i;
         for (int i = 0; i < M; i++)
            a_n[T][i] = W'(fmin(sv(a_i[T-1][i]), sv(a_i[T-1][i+M])));
      end
      always_comb begin
         fb_bad = 1'b0;
         for (int i = 0; i < M; i++)
            if (iabs(sv(a_n[T][i])) > iabs(sv(a_i[T-1][i]))) fb_bad = 1'b1;
      end
      AST_MINSUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         v_i |-> !fb_bad); // R5
   end else if (!LEAVE && RIGHT) begin : g_down_right
      always_comb begin
         a_n = a_i; bl_n = bl_i; br_n = br_i; u_n = u_i;
         for (int i = 0; i < M; i++)
            a_n[T][i] = W'(sat(fmin(sv(a_i[T-1][i]), sv(bl_i[T][i]))
                              + sv(a_i[T-1][i+M]), MX));
      end
   end else if (T == LV) begin : g_leaf
      localparam int BETA = FROZEN[J] ? MX : 0;
      always_comb begin
         int tot;
         a_n = a_i; bl_n = bl_i; br_n = br_i; u_n = u_i;
         tot = sat(sv(a_i[T][0]) + BETA, MX);
         if (RIGHT) br_n[T][0] = W'(BETA);
         else       bl_n[T][0] = W'(BETA);
         u_n[J] = FROZEN[J] ? 1'b0 : (tot < 0);
      end
   end else begin : g_up
      always_comb begin
         int lb, rb, a0, a1;
         a_n = a_i; bl_n = bl_i; br_n = br_i; u_n = u_i;
         for (int i = 0; i < H; i++) begin
            lb = sv(bl_i[T+1][i]);
            rb = sv(br_i[T+1][i]);
            a0 = sv(a_i[T][i]);
            a1 = sv(a_i[T][i+H]);
            if (RIGHT) begin
               br_n[T][i]   = W'(fmin(lb, sat(rb + a1, MX)));
               br_n[T][i+H] = W'(sat(fmin(lb, a0) + rb, MX));
            end else begin
               bl_n[T][i]   = W'(fmin(lb, sat(rb + a1, MX)));
               bl_n[T][i+H] = W'(sat(fmin(lb, a0) + rb, MX));
            end
         end
      end
   end

   logic has_min;
   always_comb begin
      has_min = 1'b0;
      for (int t = 0; t <= LV; t++)
         for (int i = 0; i < N; i++)
            if (a_n[t][i] == MINC || bl_n[t][i] == MINC || br_n[t][i] == MINC)
               has_min = 1'b1;
   end
   AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      v_i |-> !has_min); // R4

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) v_o <= 1'b0;
         else        v_o <= v_i;
      end
      always_ff @(posedge clk) begin
         a_o  <= a_n;
         bl_o <= bl_n;
         br_o <= br_n;
         u_o  <= u_n;
      end
      AST_VALID_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
         v_i |=> v_o); // R7
      AST_BUBBLE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
         !v_i |=> !v_o); // R7
   end else begin : g_wire
      assign v_o  = v_i;
      assign a_o  = a_n;
      assign bl_o = bl_n;
      assign br_o = br_n;
      assign u_o  = u_n;
   end
endmodule

// File: rtl/pscan_decoder.sv
module pscan_decoder
   import pscan_pkg::*;
#(
   parameter int           N        = 8,
   parameter int           W        = 6,
   parameter logic [N-1:0] FROZEN   = 'h17,
   parameter logic [63:0]  REG_MASK = 64'h0000_0000_0810_2040
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [N*W-1:0] in_llr,
   output logic           out_valid,
   output logic [N-1:0]   out_bits
);
   localparam int LV  = $clog2(N);
   localparam int NST = 2 * (2 * N - 2);
   localparam int LAT = popc(REG_MASK, NST);

   if (N < 2 || (1 << LV) != N) begin : g_chk_n
      $error("pscan_decoder: N must be a power of two of at least 2");
   end
   if (W < 3 || W > 16) begin : g_chk_w
      $error("pscan_decoder: W must lie in 3..16");
   end
   if (NST > 64) begin : g_chk_st
      $error("pscan_decoder: stage count exceeds the register mask width");
   end

   typedef logic [LV:0][N-1:0][W-1:0] lvec_t;

   lvec_t        sa  [NST+1];
   lvec_t        sbl [NST+1];
   lvec_t        sbr [NST+1];
   logic [N-1:0] su  [NST+1];
   logic         svl [NST+1];

   logic [N-1:0][W-1:0] cl;

   pscan_clamp #(.N(N), .W(W)) u_clamp (
      .raw (in_llr),
      .llr (cl)
   );

   assign sa[0]  = lvec_t'({{(LV*N*W){1'b0}}, cl});
   assign sbl[0] = '0;
   assign sbr[0] = '0;
   assign su[0]  = '0;
   assign svl[0] = in_valid;

   for (genvar k = 0; k < NST; k++) begin : g_st
      pscan_stage #(
         .N(N), .W(W), .LV(LV), .STEP(k), .FROZEN(FROZEN), .REG(REG_MASK[k])
      ) u_stage (
         .clk  (clk),
         .rst_n(rst_n),
         .v_i  (svl[k]),
         .a_i  (sa[k]),
         .bl_i (sbl[k]),
         .br_i (sbr[k]),
         .u_i  (su[k]),
         .v_o  (svl[k+1]),
         .a_o  (sa[k+1]),
         .bl_o (sbl[k+1]),
         .br_o (sbr[k+1]),
         .u_o  (su[k+1])
      );
   end

   assign out_valid = svl[NST];
   assign out_bits  = su[NST];

   AST_FROZEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_bits & FROZEN) == '0)); // R2

   if (LAT == 0) begin : g_comb_chk
      AST_COMB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == in_valid); // R7
   end
endmodule

// File: tb/tb_pscan_decoder.sv
module tb_pscan_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int W = 6;
   localparam logic [7:0]  FROZEN = 8'h17;
   localparam logic [63:0] M_PART = 64'h0000_0000_0810_2040;
   localparam logic [63:0] M_FULL = 64'h0000_0000_0FFF_FFFF;
   localparam logic [63:0] M_COMB = 64'h0;
   localparam int L_PART = 4;
   localparam int L_FULL = 28;
   // {message, magnitude, weak position (FF none), weak signed value}
   localparam logic [31:0] VEC [8] = '{
      32'h001F_FF00, 32'h080C_FF00, 32'h8005_FF00, 32'hE81F_FF00,
      32'h6009_0201, 32'h0014_00FF, 32'hA814_00FF, 32'h2801_FF00
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [N*W-1:0] in_llr = '0;
   logic ov_p, ov_f, ov_c;
   logic [N-1:0] ob_p, ob_f, ob_c;

   int checks = 0;
   int fails = 0;
   int k = 0;
   bit done = 1'b0;
   logic       hv [0:511];
   logic [7:0] hu [0:511];
   logic [7:0] hm [0:511];
   string      hr [0:511];

   always #(CLK_PERIOD/2) clk = ~clk;

   pscan_decoder #(.N(N), .W(W), .FROZEN(FROZEN), .REG_MASK(M_PART)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
      .out_valid(ov_p), .out_bits(ob_p));
   pscan_decoder #(.N(N), .W(W), .FROZEN(FROZEN), .REG_MASK(M_FULL)) dut_f (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
      .out_valid(ov_f), .out_bits(ob_f));
   pscan_decoder #(.N(N), .W(W), .FROZEN(FROZEN), .REG_MASK(M_COMB)) dut_c (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_llr(in_llr),
      .out_valid(ov_c), .out_bits(ob_c));

   function automatic logic [7:0] enc(logic [7:0] u);
      logic [7:0] x;
      x = u;
      for (int h = 1; h < 8; h = h * 2)
         for (int i = 0; i < 8; i++)
            if ((i & h) == 0) x[i] = x[i] ^ x[i+h];
      return x;
   endfunction

   function automatic logic [N*W-1:0] mk(logic [7:0] x, int mag, int wpos, int wval);
      logic [N*W-1:0] r;
      int v;
      r = '0;
      for (int i = 0; i < N; i++) begin
         v = (i == wpos) ? wval : mag;
         if (x[i]) v = -v;
         r[i*W +: W] = W'(v);
      end
      return r;
   endfunction

   task automatic chk(string name, logic ov, logic [7:0] ob, int idx);
      logic ev;
      ev = (idx >= 0) ? hv[idx] : 1'b0;
      checks++;
      if (ov !== ev) begin
         fails++;
         $display("FAIL R6 R7 R9 %s out_valid got %b exp %b", name, ov, ev);
      end
      if (ev === 1'b1) begin
         checks++;
         if ((ob & hm[idx]) !== (hu[idx] & hm[idx])) begin
            fails++;
            $display("FAIL %s %s out_bits got %h exp %h (mask %h)",
                     hr[idx], name, ob & hm[idx], hu[idx] & hm[idx], hm[idx]);
         end
      end
   endtask

   task automatic step(logic r, logic v, logic [N*W-1:0] llr,
                       logic [7:0] eu, logic [7:0] em, string tag);
      @(negedge clk);
      rst_n = r;
      in_valid = v;
      in_llr = llr;
      if (!r) for (int i = 0; i <= k; i++) hv[i] = 1'b0;
      hv[k] = v & r;
      hu[k] = eu;
      hm[k] = em;
      hr[k] = tag;
      #1;
      chk("dut_c", ov_c, ob_c, k);
      chk("dut", ov_p, ob_p, k - L_PART);
      chk("dut_f", ov_f, ob_f, k - L_FULL);
      k++;
   endtask

   task automatic frame(int vi, bit valid);
      logic [7:0] u;
      u = VEC[vi][31:24];
      step(1'b1, valid,
           mk(enc(u), int'(VEC[vi][23:16]),
              (VEC[vi][15:8] == 8'hFF) ? -1 : int'(VEC[vi][15:8]),
              int'($signed(VEC[vi][7:0]))),
           u, 8'hFF, (vi == 5 || vi == 6) ? "R5" : "R1 R8");
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : main
      // R9: reset state, all valids low while reset is held
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, 8'h00, 8'hFF, "R9");

      // R1 R5 R8: table walked back to back
      for (int vi = 0; vi < 8; vi++) frame(vi, 1'b1);

      // R3: all-zero frame decodes to zero
      step(1'b1, 1'b1, '0, 8'h00, 8'hFF, "R3");
      // R4: most negative code clamps; all-ones codeword of message 8'h80
      step(1'b1, 1'b1, {N{6'b100000}}, 8'h80, 8'hFF, "R4");
      // R2: frozen positions stay zero for non-codeword stimulus
      step(1'b1, 1'b1, mk(enc(8'h01), 20, -1, 0), 8'h00, FROZEN, "R2");
      step(1'b1, 1'b1, mk(enc(8'h17), 9, -1, 0), 8'h00, FROZEN, "R2");

      // R7: bubbles between frames
      frame(3, 1'b1);
      frame(2, 1'b0);
      frame(6, 1'b1);
      frame(1, 1'b0);
      frame(1, 1'b0);
      frame(4, 1'b1);

      for (int i = 0; i < 32; i++) step(1'b1, 1'b0, '0, 8'h00, 8'hFF, "R7");

      // R9: reset while frames are in flight, then watch a full depth
      for (int i = 0; i < 10; i++) frame(i % 8, 1'b1);
      step(1'b0, 1'b0, '0, 8'h00, 8'hFF, "R9");
      for (int i = 0; i < 32; i++) step(1'b1, 1'b0, '0, 8'h00, 8'hFF, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule